// File: doc/BRIEF.md
# Constant-Time Ladder Swap Sequencer

This block steps through a 256-bit secret scalar for a Montgomery-ladder point multiplication. It owns a register file that holds the X and Z coordinates of two working points, called slot A and slot B. Each coordinate is sixteen 16-bit words, with the least significant word first. On `start` the block captures a clamped copy of the scalar. It then runs 255 ladder steps for bit indices 254 down to 0.

In each step the block decides from two adjacent scalar bits whether the two points must trade places. It forms a 16-bit mask by subtracting that decision bit from a cleared word, which gives 0x0000 or 0xFFFF. It then walks every word pair of both coordinates through the masked-XOR exchange. The exchange takes the same cycles and the same register accesses whatever the bit is. After the exchange it raises `step_ready` and holds it until the field-arithmetic engine answers with `step_done`. During that pause the engine uses the host port to read and rewrite the point words. After the last step one more masked pass runs, and then `done` is raised.

The controller has six states. In IDLE it waits for `start`, which moves it to LOAD. LOAD captures the clamped scalar, sets the step index to 254 and always moves on to SWAP. SWAP spends one cycle per word index and moves to WAIT after the last word. In WAIT a `step_done` moves it to FINAL if the index is 0; otherwise it lowers the index and returns to SWAP. FINAL is a swap pass driven by bit 0 and moves to DONE after the last word. DONE waits for `start`, which moves it to LOAD.

Top module: `ladder_swap_seq`

## Requirements
- R1: On `start`, scalar bits 2..0 and bit 255 are forced to 0 and bit 254 is forced to 1. Only this clamped value steers the swaps.
- R2: One run produces exactly 255 `step_ready`/`step_done` handshakes, one for each index from 254 down to 0, before `done` rises.
- R3: The swap bit for the step at index i is clamped bit i XOR clamped bit i-1, where the bit below bit 0 counts as 0. The pass after the last step uses clamped bit 0.
- R4: The mask is 0x0000 - swap bit. Each word pair (x, y) becomes (x^t, y^t) with t = (x^y)&mask. The X and Z words of slots A and B are all exchanged when the bit is 1 and are all left unchanged when it is 0.
- R5: From the cycle in which `step_done` is accepted, `step_ready` goes low for exactly 16 cycles (one for each word index) before it rises again. This holds for either swap bit.
- R6: After the last handshake, the final pass takes 16 cycles. `done` then rises and stays high until the next `start`. `done` and `step_ready` are never high together.
- R7: `step_ready` stays high, and the register file is not changed by the block, until `step_done` is sampled high. `step_ready` then falls in the next cycle.
- R8: The host address is {bank[5:4], word[3:0]}, with bank 0 = X of slot A, 1 = Z of slot A, 2 = X of slot B and 3 = Z of slot B. `host_rdata` shows the addressed word combinationally. A write takes effect at the next clock edge. A write that arrives while a swap pass is running is ignored.
- R9: After reset all register-file words read 0, and `step_ready` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; accepted in IDLE and DONE |
| scalar | input | 256 | Secret scalar, captured and clamped on start |
| step_ready | output | 1 | Swap for the current step finished; arithmetic may run |
| step_done | input | 1 | Arithmetic for the current step finished |
| done | output | 1 | Final pass finished; slot A holds the result |
| host_we | input | 1 | Host write enable |
| host_addr | input | 6 | Register-file word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Addressed register-file word |

## Verification
The hardest case to reach from the ports is a host write that lands in the middle of a swap pass, because the arithmetic engine normally writes only during WAIT. The monitor places a write on the first clock after it hands back `step_done` at index 50, and later comparisons expect that word to be unchanged. A legal write is also made during WAIT at index 100, so later swaps must carry the new value. The scalars all-zero, all-ones and two alternating patterns give swap sequences that are almost empty, sparse and dense. All of these are compared against a full 64-word image after every step.

// File: rtl/ladder_pkg.sv
package ladder_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SWAP,
        ST_WAIT,
        ST_FINAL,
        ST_DONE
    } lad_state_t;

    localparam int NUM_BANKS = 4;

endpackage

// File: rtl/ladder_mask_gen.sv
module ladder_mask_gen #(
    parameter  int WORD_W = 16,
    parameter  int KEY_W  = 256,
    localparam int IW     = $clog2(KEY_W)
) (
    input  logic [KEY_W-1:0]  key,
    input  logic [IW-1:0]     idx,
    input  logic              final_pass,
    output logic [WORD_W-1:0] mask
);

    logic cur_bit;
    logic below_bit;
    logic swap_bit;
    logic [WORD_W-1:0] cleared;

    always_comb begin
        cur_bit   = key[idx];
        below_bit = (idx == '0) ? 1'b0 : key[idx - 1'b1];
        swap_bit  = final_pass ? key[0] : (cur_bit ^ below_bit);
    end

    // Mask by subtraction from a cleared word: 0 - 0 = 0x0000, 0 - 1 = all ones.
    assign cleared = '0;
    assign mask    = cleared - {{(WORD_W-1){1'b0}}, swap_bit};

endmodule

// File: rtl/ladder_regfile.sv
module ladder_regfile #(
    parameter  int WORD_W = 16,
    parameter  int NWORDS = 16,
    localparam int DEPTH  = 4 * NWORDS,
    localparam int AW     = $clog2(DEPTH),
    localparam int WIW    = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swap_en,
    input  logic [WIW-1:0]    swap_word,
    input  logic [WORD_W-1:0] mask,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] toggle [2];

    // Lane 0 carries the X coordinate, lane 1 the Z coordinate.
    for (genvar c = 0; c < 2; c++) begin : g_lane
        assign toggle[c] = (mem[{2'(c), swap_word}] ^ mem[{2'(c + 2), swap_word}]) & mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) begin
                mem[a] <= '0;
            end
        end else if (swap_en) begin
            for (int c = 0; c < 2; c++) begin
                mem[{2'(c), swap_word}]     <= mem[{2'(c), swap_word}] ^ toggle[c];
                mem[{2'(c + 2), swap_word}] <= mem[{2'(c + 2), swap_word}] ^ toggle[c];
            end
        end else if (host_we) begin
            mem[host_addr] <= host_wdata;
        end
    end

    assign host_rdata = mem[host_addr];

endmodule

// File: rtl/ladder_swap_ctrl.sv
module ladder_swap_ctrl
    import ladder_pkg::*;
#(
    parameter  int NWORDS = 16,
    parameter  int STEPS  = 255,
    localparam int WIW    = $clog2(NWORDS),
    localparam int IW     = $clog2(STEPS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           step_done,
    output logic           load_key,
    output logic           swap_en,
    output logic           final_pass,
    output logic           step_ready,
    output logic           done,
    output logic [IW-1:0]  step_idx,
    output logic [WIW-1:0] word_idx
);

    lad_state_t     state_q, state_d;
    logic [IW-1:0]  idx_q;
    logic [WIW-1:0] wcnt_q;
    logic           wcnt_last;

    assign wcnt_last = (wcnt_q == WIW'(NWORDS - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_SWAP;
            ST_SWAP:  if (wcnt_last) state_d = ST_WAIT;
            ST_WAIT:  if (step_done) state_d = (idx_q == '0) ? ST_FINAL : ST_SWAP;
            ST_FINAL: if (wcnt_last) state_d = ST_DONE;
            ST_DONE:  if (start) state_d = ST_LOAD;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            wcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_LOAD: begin
                    idx_q  <= IW'(STEPS - 1);
                    wcnt_q <= '0;
                end
                ST_SWAP, ST_FINAL: wcnt_q <= wcnt_last ? '0 : wcnt_q + 1'b1;
                ST_WAIT: if (step_done && idx_q != '0) idx_q <= idx_q - 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        load_key   = 1'b0;
        swap_en    = 1'b0;
        final_pass = 1'b0;
        step_ready = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_LOAD:  load_key   = 1'b1;
            ST_SWAP:  swap_en    = 1'b1;
            ST_WAIT:  step_ready = 1'b1;
            ST_FINAL: begin
                swap_en    = 1'b1;
                final_pass = 1'b1;
            end
            ST_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    assign step_idx = idx_q;
    assign word_idx = wcnt_q;

endmodule

// File: rtl/ladder_swap_seq.sv
module ladder_swap_seq #(
    parameter  int WORD_W   = 16,
    parameter  int NWORDS   = 16,
    parameter  int SCALAR_W = 256,
    localparam int AW       = $clog2(4 * NWORDS),
    localparam int WIW      = $clog2(NWORDS),
    localparam int IW       = $clog2(SCALAR_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SCALAR_W-1:0] scalar,
    output logic                step_ready,
    input  logic                step_done,
    output logic                done,
    input  logic                host_we,
    input  logic [AW-1:0]       host_addr,
    input  logic [WORD_W-1:0]   host_wdata,
    output logic [WORD_W-1:0]   host_rdata
);

    logic [SCALAR_W-1:0] key_q;
    logic [SCALAR_W-1:0] key_clamped;
    logic                load_key;
    logic                swap_en;
    logic                final_pass;
    logic [IW-1:0]       step_idx;
    logic [WIW-1:0]      word_idx;
    logic [WORD_W-1:0]   mask;

    always_comb begin
        key_clamped               = scalar;
        key_clamped[2:0]          = 3'b000;
        key_clamped[SCALAR_W-1]   = 1'b0;
        key_clamped[SCALAR_W-2]   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
        end else if (load_key) begin
            key_q <= key_clamped;
        end
    end

    ladder_swap_ctrl #(
        .NWORDS (NWORDS),
        .STEPS  (SCALAR_W - 1)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .step_done  (step_done),
        .load_key   (load_key),
        .swap_en    (swap_en),
        .final_pass (final_pass),
        .step_ready (step_ready),
        .done       (done),
        .step_idx   (step_idx),
        .word_idx   (word_idx)
    );

    ladder_mask_gen #(
        .WORD_W (WORD_W),
        .KEY_W  (SCALAR_W)
    ) u_mask (
        .key        (key_q),
        .idx        (step_idx),
        .final_pass (final_pass),
        .mask       (mask)
    );

    ladder_regfile #(
        .WORD_W (WORD_W),
        .NWORDS (NWORDS)
    ) u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .swap_en    (swap_en),
        .swap_word  (word_idx),
        .mask       (mask),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

endmodule

// File: rtl/ladder_swap_seq_chk.sv
module ladder_swap_seq_chk #(
    parameter int NWORDS = 16,
    parameter int STEPS  = 255
) (
    input logic clk,
    input logic rst_n,
    input logic step_ready,
    input logic step_done,
    input logic done
);

    logic [15:0] gap_q;
    logic [15:0] hs_q;
    logic        seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            hs_q   <= '0;
            seen_q <= 1'b0;
        end else begin
            if (step_ready)          gap_q <= '0;
            else if (gap_q != '1)    gap_q <= gap_q + 1'b1;
            if (done)                          hs_q <= '0;
            else if (step_ready && step_done)  hs_q <= hs_q + 1'b1;
            if (done)            seen_q <= 1'b0;
            else if (step_ready) seen_q <= 1'b1;
        end
    end

    // R7
    hold_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ready && !step_done) |=> step_ready);

    // R7
    release_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ready && step_done) |=> !step_ready);

    // R6
    ready_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_ready && done));

    // R5
    step_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(step_ready) && seen_q) |-> (gap_q == 16'(NWORDS)));

    // R6
    done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && seen_q) |-> (gap_q == 16'(NWORDS)));

    // R2
    step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (hs_q == 16'(STEPS)));

endmodule

bind ladder_swap_seq ladder_swap_seq_chk #(
    .NWORDS (NWORDS),
    .STEPS  (SCALAR_W - 1)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_ready (step_ready),
    .step_done  (step_done),
    .done       (done)
);

// File: tb/ladder_swap_seq_bench.sv
`timescale 1ns/1ps
module ladder_swap_seq_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [255:0] scalar = '0;
    logic         step_ready;
    logic         step_done = 1'b0;
    logic         done;
    logic         host_we = 1'b0;
    logic [5:0]   host_addr = '0;
    logic [15:0]  host_wdata = '0;
    logic [15:0]  host_rdata;

    int n_total = 0;
    int n_fail  = 0;
    bit running = 1'b0;
    bit finished = 1'b0;

    logic [15:0]   model [64];
    logic [1023:0] exp_q [$];

    always #4 clk = ~clk;

    ladder_swap_seq u_ladder_swap_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .scalar     (scalar),
        .step_ready (step_ready),
        .step_done  (step_done),
        .done       (done),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_total++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
    end

    function automatic logic [255:0] clamp(input logic [255:0] k);
        logic [255:0] c;
        c = k;
        c[2:0] = 3'b000;
        c[255] = 1'b0;
        c[254] = 1'b1;
        return c;
    endfunction

    function automatic logic [1023:0] pack_model();
        logic [1023:0] p;
        for (int a = 0; a < 64; a++) p[a*16 +: 16] = model[a];
        return p;
    endfunction

    task automatic model_swap(input bit s);
        logic [15:0] tmp;
        if (s) begin
            for (int w = 0; w < 16; w++) begin
                tmp = model[w];      model[w]      = model[32+w]; model[32+w] = tmp;
                tmp = model[16+w];   model[16+w]   = model[48+w]; model[48+w] = tmp;
            end
        end
    endtask

    task automatic host_write(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic read_image(output logic [1023:0] img);
        logic [15:0] d;
        for (int a = 0; a < 64; a++) begin
            host_read(6'(a), d);
            img[a*16 +: 16] = d;
        end
    endtask

    task automatic cmp_image(input logic [1023:0] got, input logic [1023:0] exp, input string req);
        int bad;
        bad = -1;
        for (int a = 63; a >= 0; a--) if (got[a*16 +: 16] !== exp[a*16 +: 16]) bad = a;
        if (bad < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, $sformatf("%s word %0d", req, bad), longint'(got[bad*16 +: 16]),
                 longint'(exp[bad*16 +: 16]));
    endtask

    // Driver: precomputes the expected image after every step, then starts the run.
    task automatic drive_run(input logic [255:0] k);
        logic [255:0] c;
        bit s;
        c = clamp(k);
        for (int i = 254; i >= 0; i--) begin
            s = c[i] ^ ((i > 0) ? c[i-1] : 1'b0);
            model_swap(s);
            exp_q.push_back(pack_model());
            if (i == 100) model[0] = 16'h1234;
        end
        model_swap(c[0]);
        exp_q.push_back(pack_model());
        @(negedge clk);
        scalar = k; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        running = 1'b1;
        wait (!running);
    endtask

    // Monitor: pops expected images and compares them with the register file.
    initial begin
        logic [1023:0] got;
        int gap;
        forever begin
            wait (running);
            while (!step_ready) @(negedge clk);
            for (int st = 0; st < 255; st++) begin
                read_image(got);
                cmp_image(got, exp_q.pop_front(), $sformatf("R1 R3 R4 step %0d", 254 - st));
                // R7: still waiting after many idle cycles
                chk(step_ready === 1'b1, "R7 ready held", step_ready, 1);
                if (254 - st == 100) host_write(6'd0, 16'h1234);
                @(negedge clk);
                step_done = 1'b1;
                @(negedge clk);
                step_done = 1'b0;
                gap = 0;
                while (!step_ready && !done) begin
                    // R8: write placed in the swap pass must be ignored
                    host_we = (254 - st == 50 && gap == 0);
                    host_addr = 6'd5; host_wdata = 16'hDEAD;
                    gap++;
                    @(negedge clk);
                end
                host_we = 1'b0;
                chk(gap == 16, "R5 R6 pass length", gap, 16);
                if (st < 254) chk(!done && step_ready, "R2 no early done", done, 0);
                else chk(done && !step_ready, "R2 R6 done after 255 steps", done, 1);
            end
            read_image(got);
            cmp_image(got, exp_q.pop_front(), "R3 R4 final image");
            chk(done === 1'b1, "R6 done held", done, 1);
            running = 1'b0;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(step_ready === 1'b0, "R9 step_ready reset", step_ready, 0);
        chk(done === 1'b0, "R9 done reset", done, 0);
        host_read(6'd0, d);  chk(d === 16'h0, "R9 word 0 reset", d, 0);
        host_read(6'd63, d); chk(d === 16'h0, "R9 word 63 reset", d, 0);
        for (int a = 0; a < 64; a++) begin
            model[a] = 16'h5A5A ^ {6'(a), 10'h000} ^ 16'(a * 3);
            host_write(6'(a), model[a]);
        end
        host_read(6'd17, d); chk(d === model[17], "R8 readback Z slot A", d, model[17]);
        host_read(6'd46, d); chk(d === model[46], "R8 readback X slot B", d, model[46]);
        drive_run('0);
        drive_run('1);
        drive_run({64{4'hA}});
        drive_run({32{8'h3C}});
        chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        summary();
    end

endmodule